// File: doc/BRIEF.md
# Retired-Instruction Interval Timer

This block raises a timer interrupt request after a programmable number of instructions have completed in unprivileged mode. It counts retire strobes, not clock cycles. Instructions that retire while the core is privileged do not move the count. Once raised, the request stays pending until the interrupt entry logic acknowledges it while the core is unprivileged. After that, a fresh full interval of unprivileged instructions must retire before the next request. The pipeline, the vectoring and the stack push are outside this block.

A three-state controller holds the behaviour:

- **IDLE**: the timer is disabled because the interval is zero, or the block has just come out of reset. The counter is held at zero.
- **COUNT**: unprivileged retires are counted.
- **PEND**: the request is asserted.

The transitions are:

- IDLE→COUNT when the interval is nonzero.
- COUNT→PEND on the unprivileged retire that brings the count to the interval.
- PEND→COUNT on an acknowledge taken with the privilege input low.
- COUNT→IDLE and PEND→IDLE whenever the interval reads zero.

A restart input zeroes the count without leaving the current state. The kernel pulses it on its return to user mode.

Top module: `retire_interval_timer`

## Requirements
- R1: With interval N (1..65535) and the block in COUNT, `irq_o` goes high at the rising edge that samples the N-th unprivileged retire (`retire_i`=1, `priv_i`=0), and not earlier.
- R2: A retire sampled with `priv_i`=1 does not advance the count.
- R3: After an accepted acknowledge the count restarts from zero, and the request rises again only on the N-th further unprivileged retire. A retire in the acknowledge cycle itself is not counted.
- R4: While `priv_i`=1 a pending request stays high, and `ack_i` has no effect.
- R5: `ack_i`=1 with `priv_i`=0 while the request is pending drops `irq_o` at that edge.
- R6: Interval zero disables the timer. No request is raised, and a pending request drops at the next edge. When the interval becomes nonzero again, the block spends one cycle in IDLE, in which a retire is not counted.
- R7: `restart_i`=1 zeroes the count. A retire in the same cycle is not counted, and a pending request is unaffected.
- R8: Synchronous active-high reset `rst` clears the request and the count and enters IDLE. A retire in the first cycle after reset is not counted.
- R9: If the interval is lowered to or below the current count, the next unprivileged retire raises the request.
- R10: Unprivileged retires that occur while the request is pending are not counted toward the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One-cycle pulse per completed instruction |
| priv_i | input | 1 | 1 = core is in privileged mode |
| interval_i | input | CNT_W | Unprivileged instructions per request; 0 disables |
| ack_i | input | 1 | Acknowledge from interrupt entry logic |
| restart_i | input | 1 | Zero the count (return to user mode) |
| irq_o | output | 1 | Pending timer request |

## Verification
The assertions rely on a few assumptions about the inputs:

- `retire_i` is a single-cycle pulse per instruction.
- `ack_i` arrives only while a request is pending.
- Inputs change only between clock edges.

The bench drives every input at the falling edge and holds it for exactly one cycle. It issues acknowledges only after it has seen the request high. The sweep covers intervals 1 to 12 with several privileged/unprivileged interleavings. In each case it predicts the firing retire by counting only the unprivileged strobes.

// File: rtl/rit_pkg.sv
package rit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PEND  = 2'd2
    } rit_state_t;

endpackage

// File: rtl/rit_count.sv
module rit_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             reach_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_plus;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        cnt_plus = {1'b0, cnt_q} + 1'b1;
        reach_o  = cnt_plus >= {1'b0, limit_i};
    end

    assign cnt_o = cnt_q;

    // R1: the count never increments past its top value
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        inc_i |-> (cnt_q != CNT_MAX));

    // R7: a clear always leaves the count at zero
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rit_ctrl.sv
module rit_ctrl
    import rit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic retire_i,
    input  logic priv_i,
    input  logic ack_i,
    input  logic restart_i,
    input  logic limit_zero_i,
    input  logic reach_i,
    output logic inc_o,
    output logic clr_o,
    output logic irq_o
);

    rit_state_t state_q, state_d;
    logic       take;
    logic       ack_ok;

    always_comb begin
        take   = retire_i && !priv_i && !restart_i;
        ack_ok = ack_i && !priv_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!limit_zero_i) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (limit_zero_i)          state_d = ST_IDLE;
                else if (take && reach_i)  state_d = ST_PEND;
            end
            ST_PEND: begin
                if (limit_zero_i)  state_d = ST_IDLE;
                else if (ack_ok)   state_d = ST_COUNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        inc_o = 1'b0;
        clr_o = restart_i;
        irq_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  clr_o = 1'b1;
            ST_COUNT: inc_o = take && !reach_i && !limit_zero_i;
            ST_PEND: begin
                irq_o = 1'b1;
                if (ack_ok) clr_o = 1'b1;
            end
            default: clr_o = 1'b1;
        endcase
    end

    // R4: a pending request survives privileged cycles
    assert_hold_priv_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_o && priv_i && !limit_zero_i) |=> irq_o);

    // R5: an accepted acknowledge removes the request
    assert_ack_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_o && ack_i && !priv_i) |=> !irq_o);

    // R6: zero interval never leaves a request standing
    assert_zero_off_R6: assert property (@(posedge clk) disable iff (rst)
        limit_zero_i |=> !irq_o);

    // R2: a new request is always caused by an unprivileged retire
    assert_rise_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(retire_i && !priv_i && !restart_i));

    // R10: no counting while a request is pending
    assert_pend_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !inc_o);

endmodule

// File: rtl/retire_interval_timer.sv
module retire_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retire_i,
    input  logic             priv_i,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             ack_i,
    input  logic             restart_i,
    output logic             irq_o
);

    logic [CNT_W-1:0] cnt;
    logic             reach;
    logic             inc;
    logic             clr;
    logic             limit_zero;

    assign limit_zero = (interval_i == '0);

    rit_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr),
        .inc_i   (inc),
        .limit_i (interval_i),
        .cnt_o   (cnt),
        .reach_o (reach)
    );

    rit_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .retire_i     (retire_i),
        .priv_i       (priv_i),
        .ack_i        (ack_i),
        .restart_i    (restart_i),
        .limit_zero_i (limit_zero),
        .reach_i      (reach),
        .inc_o        (inc),
        .clr_o        (clr),
        .irq_o        (irq_o)
    );

    // R2: a privileged retire leaves the count unchanged
    assert_priv_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (retire_i && priv_i && !restart_i && !ack_i && !limit_zero) |=> $stable(cnt));

endmodule

// File: tb/test_retire_interval_timer.sv
module test_retire_interval_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        retire_i, priv_i, ack_i, restart_i;
    logic [15:0] interval_i;
    logic        irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    retire_interval_timer i_retire_interval_timer (
        .clk        (clk),
        .rst        (rst),
        .retire_i   (retire_i),
        .priv_i     (priv_i),
        .interval_i (interval_i),
        .ack_i      (ack_i),
        .restart_i  (restart_i),
        .irq_o      (irq_o)
    );

    task automatic check(input string req, input logic exp);
        total++;
        if (irq_o !== exp) begin
            bad++;
            $display("FAIL %s: irq_o=%b expected=%b at %0t", req, irq_o, exp, $time);
        end
    endtask

    task automatic cyc(input logic r, input logic p, input logic a, input logic rs);
        retire_i  = r;
        priv_i    = p;
        ack_i     = a;
        restart_i = rs;
        @(negedge clk);
        retire_i  = 1'b0;
        ack_i     = 1'b0;
        restart_i = 1'b0;
    endtask

    task automatic set_interval(input int n);
        interval_i = 16'(0);
        cyc(0, 0, 0, 0);
        check("R6", 1'b0);
        interval_i = 16'(n);
        cyc(0, 0, 0, 0);
    endtask

    task automatic run_to_fire(input int n, input int pat, input string req);
        int cnt = 0;
        int k = 0;
        while (cnt < n) begin
            logic p;
            p = (pat != 0) && ((k % (pat + 1)) == 0);
            cyc(1, p, 0, 0);
            if (!p) cnt++;
            check(p ? "R2" : req, cnt >= n);
            k++;
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        retire_i = 0; priv_i = 0; ack_i = 0; restart_i = 0;
        interval_i = 16'd4;
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R8", 1'b0);
        rst = 1'b0;
        cyc(1, 0, 0, 0);
        check("R8", 1'b0);
        for (int i = 1; i <= 4; i++) begin
            cyc(1, 0, 0, 0);
            check("R8", i == 4);
        end
        cyc(1, 0, 1, 0);
        check("R5", 1'b0);

        for (int n = 1; n <= 12; n++) begin
            for (int pat = 0; pat < 4; pat++) begin
                set_interval(n);
                run_to_fire(n, pat, "R1");
                for (int j = 0; j < 3; j++) begin
                    cyc(1, 1, 0, 0);
                    check("R4", 1'b1);
                end
                cyc(0, 1, 1, 0);
                check("R4", 1'b1);
                cyc(1, 0, 0, 0);
                check("R10", 1'b1);
                cyc(1, 0, 1, 0);
                check("R5", 1'b0);
                run_to_fire(n, (pat + 1) % 4, "R3");
            end
        end

        set_interval(3);
        for (int j = 0; j < 4; j++) begin
            cyc(1, 0, 0, 0);
        end
        check("R10", 1'b1);
        cyc(0, 0, 1, 0);
        check("R5", 1'b0);
        cyc(1, 0, 0, 0);
        check("R10", 1'b0);
        cyc(1, 0, 0, 0);
        check("R10", 1'b0);
        cyc(1, 0, 0, 0);
        check("R10", 1'b1);

        set_interval(5);
        for (int j = 0; j < 3; j++) cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 1);
        check("R7", 1'b0);
        for (int j = 1; j <= 5; j++) begin
            cyc(1, 0, 0, 0);
            check("R7", j == 5);
        end
        cyc(1, 0, 0, 1);
        check("R7", 1'b1);

        set_interval(10);
        for (int j = 0; j < 6; j++) cyc(1, 0, 0, 0);
        check("R9", 1'b0);
        interval_i = 16'd4;
        cyc(0, 0, 0, 0);
        check("R9", 1'b0);
        cyc(1, 0, 0, 0);
        check("R9", 1'b1);

        interval_i = 16'd0;
        cyc(0, 1, 0, 0);
        check("R6", 1'b0);
        for (int j = 0; j < 20; j++) begin
            cyc(1, 0, 0, 0);
            check("R6", 1'b0);
        end
        interval_i = 16'd2;
        cyc(1, 0, 0, 0);
        check("R6", 1'b0);
        cyc(1, 0, 0, 0);
        check("R6", 1'b0);
        cyc(1, 0, 0, 0);
        check("R6", 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule